// File: doc/BRIEF.md
# Four-Channel Quarter-Wave Sine Generator

This block produces four independent signed sine sample streams from a constant table that holds only the first quarter of a sine period. Each channel owns a 32-bit phase accumulator. The accumulator's top two bits select the quadrant, and the table rebuilds the other three quarters by mirroring the lookup address and negating the result. A channel's frequency is set by its per-cycle phase increment. Its starting phase is set by the value that its accumulator reloads.

The increment and the starting phase are written while the block is idle. A start request arms the block. The first trigger then loads every accumulator with its starting phase and begins the run. Each later trigger during the run reloads all four phases together, so the channels stay aligned to an external repetition pulse. A stop request ends the run and returns the block to idle. Samples come out two cycles after the accumulator value they represent, each with a per-channel valid flag.

Top module: `qwsg_top`

## Requirements
- R1: While reset is asserted, and afterwards until the first run, every `sampleValid` bit is 0 and every sample is 0. Reset clears every increment and starting phase to 0 and puts the control in idle.
- R2: A configuration write (`cfgWe`=1) is accepted only while idle. It sets the increment to `cfgStep` and the starting phase to `cfgPhase` of the channel numbered `cfgSel` (0..3) and leaves the other channels unchanged. A write in any other state has no effect.
- R3: A written increment larger than 2^27 is stored as 2^27, so that every period has at least 32 samples. An increment of exactly 2^27 is stored unchanged.
- R4: `startReq` while idle moves the control to the armed state. In the armed state the accumulators hold their values and no valid sample appears until a trigger arrives.
- R5: `trigIn` while armed or running, without `stopReq`, loads every accumulator with its starting phase at that clock edge. The first valid sample after the trigger is the sample for that starting phase. `trigIn` while idle has no effect.
- R6: While running, each accumulator adds its increment every cycle, modulo 2^32.
- R7: Accumulator bits [31:30] give the quadrant, and bits [29:22] give the table index a. In quadrants 1 and 3 the index used is 255-a. In quadrants 2 and 3 the sample is the two's-complement negation of the table value.
- R8: Table entry k (0..255) equals round((2^23-1)*sin(pi*(2k+1)/1024)). The output sample is the 24-bit signed value of that entry, with the sign set by R7.
- R9: `sampleValid` is 1 exactly two cycles after a cycle in which the control is running, and each sample corresponds to the accumulator value of that cycle. A stop request while running or armed returns the control to idle.
- R10: When `stopReq` and `trigIn` arrive in the same running cycle, the stop takes effect and no phase reload occurs.
- R11: A sample is 0 whenever its valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Channel addressed by a write |
| cfgStep | input | 32 | Phase increment to write |
| cfgPhase | input | 32 | Starting phase to write |
| startReq | input | 1 | Arms the block from idle |
| stopReq | input | 1 | Ends the run or leaves the armed state |
| trigIn | input | 1 | Starts the run, or reloads all phases during a run |
| sampleOut | output | 96 | Channel c sample at bits [24c+23:24c], signed |
| sampleValid | output | 4 | Per-channel sample valid |

## Verification
Channel 0 steps by exactly one table entry per cycle from phase zero. Over 1024 run cycles it covers every index in all four quadrants, which separates index mirroring errors from sign errors. The other channels use an odd increment with low-order bits set, the exact 32-point boundary increment, and an oversized increment that must be capped. Their starting phases fall in different quadrants, which exercises the carry into the quadrant bits and the cap. Later stimuli send a trigger during the run, attempt a write during the run, assert stop and trigger together, and reconfigure a single channel in idle. These tell phase reload, write gating, stop priority and channel select apart from plain free-running behaviour.

// File: rtl/qwsg_pkg.sv
package qwsg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgAccept;
    logic loadPhase;
    logic advance;
    logic running;
  } chanCtl_t;

endpackage

// File: rtl/qwsg_chan.sv
module qwsg_chan
  import qwsg_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int SAMPLE_W = 24,
  parameter int TBL_AW   = 8,
  parameter int MIN_PTS  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ACC_W-1:0]    wrStep,
  input  logic [ACC_W-1:0]    wrPhase,
  input  chanCtl_t            ctl,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                validOut
);
  localparam int MAG_W    = SAMPLE_W - 1;
  localparam int DEPTH    = 1 << TBL_AW;
  localparam int STEP_SH  = ACC_W - $clog2(MIN_PTS);
  localparam logic [ACC_W-1:0] MAX_STEP = ACC_W'(1) << STEP_SH;

  function automatic logic [DEPTH*MAG_W-1:0] buildTable();
    logic [DEPTH*MAG_W-1:0] t;
    real amp;
    real ang;
    t   = '0;
    amp = (2.0 ** MAG_W) - 1.0;
    for (int k = 0; k < DEPTH; k++) begin
      ang = 3.14159265358979323846 * (2.0 * k + 1.0) / (4.0 * DEPTH);
      t[k*MAG_W +: MAG_W] = MAG_W'($rtoi(amp * $sin(ang) + 0.5));
    end
    return t;
  endfunction

  localparam logic [DEPTH*MAG_W-1:0] QTABLE = buildTable();

  logic [ACC_W-1:0]  stepReg;
  logic [ACC_W-1:0]  phaseReg;
  logic [ACC_W-1:0]  acc;
  logic [1:0]        quad;
  logic [TBL_AW-1:0] rawIdx;
  logic [TBL_AW-1:0] tblIdx;
  logic [MAG_W-1:0]  romQ;
  logic              negQ;
  logic              validS1;
  logic [SAMPLE_W-1:0] magExt;

  // configuration registers with increment cap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepReg  <= '0;
      phaseReg <= '0;
    end else if (wrEn) begin
      stepReg  <= (wrStep > MAX_STEP) ? MAX_STEP : wrStep;
      phaseReg <= wrPhase;
    end
  end

  // phase accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (ctl.loadPhase) begin
      acc <= phaseReg;
    end else if (ctl.advance) begin
      acc <= acc + stepReg;
    end
  end

  // quadrant decode and mirrored lookup
  assign quad   = acc[ACC_W-1 -: 2];
  assign rawIdx = acc[ACC_W-3 -: TBL_AW];
  assign tblIdx = quad[0] ? ~rawIdx : rawIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romQ    <= '0;
      negQ    <= 1'b0;
      validS1 <= 1'b0;
    end else begin
      romQ    <= QTABLE[int'(tblIdx)*MAG_W +: MAG_W];
      negQ    <= quad[1];
      validS1 <= ctl.running;
    end
  end

  assign magExt = {1'b0, romQ};

  // sign restore and output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut <= '0;
      validOut  <= 1'b0;
    end else begin
      validOut  <= validS1;
      if (validS1)
        sampleOut <= negQ ? (~magExt + SAMPLE_W'(1)) : magExt;
      else
        sampleOut <= '0;
    end
  end

  p_step_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    stepReg <= MAX_STEP);

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(stepReg) && $stable(phaseReg)));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadPhase |=> (acc == $past(phaseReg)));

  p_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.loadPhase) |=> (acc == $past(acc) + $past(stepReg)));

  p_valid_lag_r9: assert property (@(posedge clk) disable iff (!rstN)
    validOut == $past(ctl.running, 2));

  p_sign_r7: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (sampleOut[SAMPLE_W-1] == $past(acc[ACC_W-1], 2)));

  p_zero_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> (sampleOut == '0));

endmodule

// File: rtl/qwsg_datapath.sv
module qwsg_datapath
  import qwsg_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ACC_W    = 32,
  parameter int SAMPLE_W = 24,
  parameter int TBL_AW   = 8,
  parameter int MIN_PTS  = 32,
  localparam int SEL_W   = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  chanCtl_t                   ctl,
  input  logic [SEL_W-1:0]           cfgSel,
  input  logic [ACC_W-1:0]           cfgStep,
  input  logic [ACC_W-1:0]           cfgPhase,
  output logic [NUM_CH*SAMPLE_W-1:0] sampleOut,
  output logic [NUM_CH-1:0]          sampleValid
);
  logic [NUM_CH-1:0] chWr;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chWr[i] = ctl.cfgAccept && (cfgSel == SEL_W'(i));

    qwsg_chan #(
      .ACC_W    (ACC_W),
      .SAMPLE_W (SAMPLE_W),
      .TBL_AW   (TBL_AW),
      .MIN_PTS  (MIN_PTS)
    ) chan_i (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (chWr[i]),
      .wrStep    (cfgStep),
      .wrPhase   (cfgPhase),
      .ctl       (ctl),
      .sampleOut (sampleOut[i*SAMPLE_W +: SAMPLE_W]),
      .validOut  (sampleValid[i])
    );
  end

  p_one_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chWr));

endmodule

// File: rtl/qwsg_ctrl.sv
module qwsg_ctrl
  import qwsg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWe,
  input  logic     startReq,
  input  logic     stopReq,
  input  logic     trigIn,
  output chanCtl_t ctl
);
  ctrlState_t state;
  ctrlState_t stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (startReq) stateNext = ST_ARMED;
      ST_ARMED: if (stopReq) stateNext = ST_IDLE;
                else if (trigIn) stateNext = ST_RUN;
      ST_RUN:   if (stopReq) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.cfgAccept = cfgWe && (state == ST_IDLE);
    ctl.loadPhase = trigIn && !stopReq && (state != ST_IDLE);
    ctl.advance   = (state == ST_RUN);
    ctl.running   = (state == ST_RUN);
  end

  p_start_arms_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> (state == ST_ARMED));

  p_trig_runs_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && trigIn && !stopReq) |=> (state == ST_RUN));

  p_stop_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stopReq) |=> (state == ST_IDLE));

  p_armed_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && !trigIn && !stopReq) |=> (state == ST_ARMED));

endmodule

// File: rtl/qwsg_top.sv
module qwsg_top
  import qwsg_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ACC_W    = 32,
  parameter int SAMPLE_W = 24,
  parameter int TBL_AW   = 8,
  parameter int MIN_PTS  = 32,
  localparam int SEL_W   = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [SEL_W-1:0]           cfgSel,
  input  logic [ACC_W-1:0]           cfgStep,
  input  logic [ACC_W-1:0]           cfgPhase,
  input  logic                       startReq,
  input  logic                       stopReq,
  input  logic                       trigIn,
  output logic [NUM_CH*SAMPLE_W-1:0] sampleOut,
  output logic [NUM_CH-1:0]          sampleValid
);
  chanCtl_t ctl;

  qwsg_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .startReq (startReq),
    .stopReq  (stopReq),
    .trigIn   (trigIn),
    .ctl      (ctl)
  );

  qwsg_datapath #(
    .NUM_CH   (NUM_CH),
    .ACC_W    (ACC_W),
    .SAMPLE_W (SAMPLE_W),
    .TBL_AW   (TBL_AW),
    .MIN_PTS  (MIN_PTS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cfgSel      (cfgSel),
    .cfgStep     (cfgStep),
    .cfgPhase    (cfgPhase),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: tb/qwsg_top_tb_top.sv
`timescale 1ns/1ps
module qwsg_top_tb_top;
  localparam int NCH = 4;
  localparam logic [31:0] CAP = 32'h0800_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgStep = '0;
  logic [31:0] cfgPhase = '0;
  logic        startReq = 1'b0;
  logic        stopReq = 1'b0;
  logic        trigIn = 1'b0;
  logic [NCH*24-1:0] sampleOut;
  logic [NCH-1:0]    sampleValid;

  int checks = 0;
  int failures = 0;

  // model state: 0 idle, 1 armed, 2 run
  int          mState = 0;
  logic [31:0] mStep [NCH];
  logic [31:0] mPh   [NCH];
  logic [31:0] mAcc  [NCH];
  logic        m1V = 1'b0;
  logic        m2V = 1'b0;
  logic [23:0] m1S [NCH];
  logic [23:0] m2S [NCH];

  always #5 clk = ~clk;

  qwsg_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgStep(cfgStep), .cfgPhase(cfgPhase), .startReq(startReq),
    .stopReq(stopReq), .trigIn(trigIn),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  function automatic logic [23:0] refMag(int k);
    real ang;
    ang = 3.14159265358979323846 * (2.0 * k + 1.0) / 1024.0;
    return 24'($rtoi(8388607.0 * $sin(ang) + 0.5));
  endfunction

  function automatic logic [23:0] refSample(logic [31:0] a);
    int idx;
    logic [23:0] m;
    idx = int'(a[29:22]);
    if (a[30]) idx = 255 - idx;
    m = refMag(idx);
    return a[31] ? (24'd0 - m) : m;
  endfunction

  task automatic compareAll(input string tag);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (sampleValid[c] !== m2V || sampleOut[c*24 +: 24] !== m2S[c]) begin
        failures++;
        $display("FAIL %s ch%0d: valid=%b sample=%h expected valid=%b sample=%h",
                 tag, c, sampleValid[c], sampleOut[c*24 +: 24], m2V, m2S[c]);
      end
    end
  endtask

  // called at a negative edge; drives inputs, models the next edge, checks after it
  task automatic tick(input logic st, input logic sp, input logic tg,
                      input logic we, input logic [1:0] sel,
                      input logic [31:0] stp, input logic [31:0] ph,
                      input string tag);
    logic load;
    logic adv;
    startReq = st; stopReq = sp; trigIn = tg;
    cfgWe = we; cfgSel = sel; cfgStep = stp; cfgPhase = ph;
    m2V = m1V;
    for (int c = 0; c < NCH; c++) m2S[c] = m1S[c];
    m1V = (mState == 2);
    for (int c = 0; c < NCH; c++) m1S[c] = m1V ? refSample(mAcc[c]) : 24'd0;
    load = tg && !sp && (mState != 0);
    adv  = (mState == 2);
    for (int c = 0; c < NCH; c++) begin
      if (load) mAcc[c] = mPh[c];
      else if (adv) mAcc[c] = mAcc[c] + mStep[c];
    end
    if (we && mState == 0) begin
      mStep[sel] = (stp > CAP) ? CAP : stp;
      mPh[sel]   = ph;
    end
    case (mState)
      0: if (st) mState = 1;
      1: if (sp) mState = 0; else if (tg) mState = 2;
      default: if (sp) mState = 0;
    endcase
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idleTicks(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 2'd0, 32'd0, 32'd0, tag);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mStep[c] = '0; mPh[c] = '0; mAcc[c] = '0; m1S[c] = '0; m2S[c] = '0;
    end
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    idleTicks(3, "R1 after reset");
    // trigger while idle has no effect (R5)
    tick(0, 0, 1, 0, 2'd0, 32'd0, 32'd0, "R5 idle trigger");
    // configuration (R2, R3)
    tick(0, 0, 0, 1, 2'd0, 32'h0040_0000, 32'h0000_0000, "R2 cfg ch0");
    tick(0, 0, 0, 1, 2'd1, 32'h0123_4567, 32'h4000_0000, "R2 cfg ch1");
    tick(0, 0, 0, 1, 2'd2, 32'h0800_0000, 32'h9000_0000, "R3 cfg ch2 boundary");
    tick(0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF, 32'hC000_0001, "R3 cfg ch3 capped");
    // arm and wait (R4)
    tick(1, 0, 0, 0, 2'd0, 32'd0, 32'd0, "R4 start");
    idleTicks(5, "R4 armed no output");
    // trigger starts the run (R5) then exhaustive sweep on ch0
    tick(0, 0, 1, 0, 2'd0, 32'd0, 32'd0, "R5 first trigger");
    idleTicks(2, "R5 R9 first samples");
    idleTicks(1030, "R6 R7 R8 sweep");
    // write during run ignored (R2)
    tick(0, 0, 0, 1, 2'd0, 32'h0000_0005, 32'h1234_5678, "R2 write in run");
    idleTicks(20, "R2 write ignored");
    // reload during run (R5)
    tick(0, 0, 1, 0, 2'd0, 32'd0, 32'd0, "R5 trigger in run");
    idleTicks(10, "R5 reload");
    // stop and trigger together (R10), then output drains (R9, R11)
    tick(0, 1, 1, 0, 2'd0, 32'd0, 32'd0, "R10 stop with trigger");
    idleTicks(6, "R9 R11 drain");
    // reconfigure one channel only (R2)
    tick(0, 0, 0, 1, 2'd2, 32'h0031_0000, 32'h2200_0000, "R2 select ch2");
    tick(1, 0, 0, 0, 2'd0, 32'd0, 32'd0, "R4 restart");
    tick(0, 0, 1, 0, 2'd0, 32'd0, 32'd0, "R5 retrigger");
    idleTicks(60, "R2 R6 second run");
    tick(0, 1, 0, 0, 2'd0, 32'd0, 32'd0, "R9 stop");
    idleTicks(4, "R9 R11 stopped");
    // stop while armed (R9)
    tick(1, 0, 0, 0, 2'd0, 32'd0, 32'd0, "R4 arm again");
    tick(0, 1, 0, 0, 2'd0, 32'd0, 32'd0, "R9 stop armed");
    tick(0, 0, 1, 0, 2'd0, 32'd0, 32'd0, "R5 trigger after stop");
    idleTicks(4, "R9 stays idle");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule